// File: doc/BRIEF.md
# Packed Complex Fixed-Point Multiply-Accumulate Datapath

This block is the arithmetic stage of a vector accelerator that works on matrices of complex fixed-point numbers. Each beat of its input stream carries `LANES` complex columns of operand A and operand B, plus an optional per-row scale factor. For one command, every element is turned into a term by one of three element-wise operations: a complex scale (alpha times A), a conjugate product (A times the conjugate of B), or a plain complex sum (A plus B). The terms either go straight out, one result beat per input beat, or are summed down each column into a wide accumulator bank. After the last row the bank is read out as a single result row.

Terms and accumulations are kept at full precision. Quantization to the output width is done exactly once, just before a value leaves the block. It uses either floor or round-half-up, and either two's-complement wrap or saturation. A command is started with a one-cycle `cmd_start` while the block is idle. The row count and the beats per row are given with the command. `done` pulses once the last result beat has been taken.

Top module: `cvmac_core`

## Requirements
- R1: With op code 0 and `cmd_alpha_direct` set, each term is k*A, where k is the complex immediate `cmd_alpha` (real in bits 7:0, imaginary in bits 15:8). `in_alpha` has no effect in this mode.
- R2: With op code 0 and `cmd_alpha_direct` clear, the k of a row is the `in_alpha` value present on the beat that carries `in_first`. The same k applies to every beat of that row.
- R3: Op code 1 gives the term A*conj(B): real = ar*br + ai*bi, imaginary = ai*br - ar*bi.
- R4: Op code 2 gives the term A+B. Op code 3 gives a zero term.
- R5: Lane l of `in_a`/`in_b` occupies bits [16l+15:16l], with the real part in the low byte. Lane l of `out_data` occupies bits [16l+15:16l], with the real part in the low byte. Every component is a signed value with 4 fractional bits.
- R6: With `cmd_reduce` clear, every accepted input beat produces exactly one output beat, in input order. That output beat is presented on the cycle after the input beat is accepted.
- R7: With `cmd_reduce` set, no output appears while rows are taken. After the last row, `cmd_beats` output beats follow in column order. Each holds the sum of its column's terms over all rows of this command only. The sum is formed at full precision and quantized once.
- R8: Quantization keeps 4 fractional bits. With `cmd_round` clear it yields floor(x*16). With `cmd_round` set it yields floor(x*16 + 1/2).
- R9: With `cmd_sat` set, results clamp to [-128, 127]. With it clear, results wrap modulo 256.
- R10: While `out_valid` is high and `out_ready` is low, `out_data` stays unchanged. In non-reduce mode `in_ready` is low during that time.
- R11: `done` is high for exactly one cycle: the cycle after the last output beat of a command is accepted.
- R12: After reset, `out_valid`, `done` and `in_ready` are low. `in_ready` stays low while no command is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_start | input | 1 | Starts a command when the block is idle |
| cmd_op | input | 2 | Operation: 0 scale, 1 conjugate product, 2 sum, 3 zero |
| cmd_reduce | input | 1 | Sum terms down each column |
| cmd_round | input | 1 | Round half up instead of floor |
| cmd_sat | input | 1 | Saturate instead of wrap |
| cmd_alpha_direct | input | 1 | Use `cmd_alpha` for every row |
| cmd_alpha | input | 16 | Complex immediate scale {imag, real} |
| cmd_rows | input | 7 | Number of rows (at least 1) |
| cmd_beats | input | 4 | Beats per row (1 to 8) |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Input beat accepted when high together with valid |
| in_first | input | 1 | Marks the first beat of a row |
| in_a | input | 32 | Packed A lanes |
| in_b | input | 32 | Packed B lanes |
| in_alpha | input | 16 | Per-row scale {imag, real}, read on a first beat |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Output beat taken |
| out_data | output | 32 | Packed quantized result lanes |
| done | output | 1 | One-cycle end-of-command pulse |

## Verification
The hardest case to reach is the reduce readout under output backpressure. The accumulator bank is read through the output register while `out_ready` toggles. A bank-index or hold error would only show as a shifted or duplicated column. The stimulus therefore runs full-width reductions over several rows with random gaps on both streams. It then issues a second reduce command right after the first, so that stale accumulator contents would show. Magnitudes near the output limits, with rounding and saturation both on and off, reach the clamp, wrap and half-way rounding paths.

// File: rtl/cvmac_pkg.sv
package cvmac_pkg;

    typedef enum logic [1:0] {
        OP_SCALE = 2'd0,
        OP_CONJ  = 2'd1,
        OP_ADD   = 2'd2,
        OP_NONE  = 2'd3
    } vop_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_DRAIN = 2'd2,
        ST_FLUSH = 2'd3
    } vst_e;

    localparam int DEF_DW    = 8;
    localparam int DEF_FB    = 4;
    localparam int DEF_ACCW  = 48;
    localparam int DEF_OW    = 8;

    // width of one unquantized term: a full complex product plus headroom
    function automatic int term_width(input int dw);
        return 2 * dw + 2;
    endfunction

endpackage

// File: rtl/cvmac_lane.sv
module cvmac_lane
    import cvmac_pkg::*;
#(
    parameter int DW = DEF_DW,
    parameter int FB = DEF_FB,
    parameter int TW = term_width(DW)
) (
    input  vop_e                  op,
    input  logic signed [DW-1:0]  a_re,
    input  logic signed [DW-1:0]  a_im,
    input  logic signed [DW-1:0]  b_re,
    input  logic signed [DW-1:0]  b_im,
    input  logic signed [DW-1:0]  k_re,
    input  logic signed [DW-1:0]  k_im,
    output logic signed [TW-1:0]  t_re,
    output logic signed [TW-1:0]  t_im
);
    logic signed [TW-1:0] ar, ai, br, bi, kr, ki;

    assign ar = TW'(a_re);
    assign ai = TW'(a_im);
    assign br = TW'(b_re);
    assign bi = TW'(b_im);
    assign kr = TW'(k_re);
    assign ki = TW'(k_im);

    // all terms carry 2*FB fractional bits
    always_comb begin
        unique case (op)
            OP_SCALE: begin
                t_re = kr * ar - ki * ai;
                t_im = kr * ai + ki * ar;
            end
            OP_CONJ: begin
                t_re = ar * br + ai * bi;
                t_im = ai * br - ar * bi;
            end
            OP_ADD: begin
                t_re = (ar + br) <<< FB;
                t_im = (ai + bi) <<< FB;
            end
            default: begin
                t_re = '0;
                t_im = '0;
            end
        endcase
    end
endmodule

// File: rtl/cvmac_quant.sv
module cvmac_quant #(
    parameter int IW = 48,
    parameter int FB = 4,
    parameter int OW = 8
) (
    input  logic signed [IW-1:0] x,
    input  logic                 rnd,
    input  logic                 sat,
    output logic [OW-1:0]        y
);
    // input has 2*FB fractional bits, output keeps FB
    localparam logic signed [IW-1:0] HALF = IW'(1) << (FB - 1);
    localparam logic signed [IW-1:0] MAXV = (IW'(1) << (OW - 1)) - IW'(1);
    localparam logic signed [IW-1:0] MINV = -MAXV - IW'(1);

    logic signed [IW-1:0] biased, shifted;

    always_comb begin
        biased  = rnd ? (x + HALF) : x;
        shifted = biased >>> FB;
        if (sat && (shifted > MAXV))
            y = MAXV[OW-1:0];
        else if (sat && (shifted < MINV))
            y = MINV[OW-1:0];
        else
            y = shifted[OW-1:0];
    end
endmodule

// File: rtl/cvmac_core.sv
module cvmac_core
    import cvmac_pkg::*;
#(
    parameter int LANES   = 2,
    parameter int DW      = DEF_DW,
    parameter int FB      = DEF_FB,
    parameter int ACCW    = DEF_ACCW,
    parameter int OW      = DEF_OW,
    parameter int MAXCOLS = 16,
    parameter int MAXROWS = 64,
    localparam int EW       = 2 * DW,
    localparam int OEW      = 2 * OW,
    localparam int MAXBEATS = MAXCOLS / LANES,
    localparam int BCW      = $clog2(MAXBEATS + 1),
    localparam int RCW      = $clog2(MAXROWS + 1)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   cmd_start,
    input  logic [1:0]             cmd_op,
    input  logic                   cmd_reduce,
    input  logic                   cmd_round,
    input  logic                   cmd_sat,
    input  logic                   cmd_alpha_direct,
    input  logic [EW-1:0]          cmd_alpha,
    input  logic [RCW-1:0]         cmd_rows,
    input  logic [BCW-1:0]         cmd_beats,
    input  logic                   in_valid,
    output logic                   in_ready,
    input  logic                   in_first,
    input  logic [LANES*EW-1:0]    in_a,
    input  logic [LANES*EW-1:0]    in_b,
    input  logic [EW-1:0]          in_alpha,
    output logic                   out_valid,
    input  logic                   out_ready,
    output logic [LANES*OEW-1:0]   out_data,
    output logic                   done
);
    localparam int TW  = term_width(DW);
    localparam int BIW = (MAXBEATS > 1) ? $clog2(MAXBEATS) : 1;

    typedef struct packed {
        logic signed [ACCW-1:0] re;
        logic signed [ACCW-1:0] im;
    } acc_t;

    vst_e             st;
    vop_e             op_q;
    logic             red_q, rnd_q, sat_q, dir_q;
    logic [EW-1:0]    kimm_q, krow_q, kcur;
    logic [RCW-1:0]   rows_q, row_cnt;
    logic [BCW-1:0]   beats_q, col_cnt;
    logic             ov, done_q;
    logic [LANES*OEW-1:0] od, qbeat;
    logic             take, out_free, last_col, last_row;

    assign out_free = !ov || out_ready;
    assign in_ready = (st == ST_RUN) && (red_q || out_free);
    assign take     = in_valid && in_ready;
    assign last_col = (col_cnt == beats_q - BCW'(1));
    assign last_row = (row_cnt == rows_q - RCW'(1));
    assign kcur     = dir_q ? kimm_q : (in_first ? in_alpha : krow_q);

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic signed [TW-1:0]   t_re, t_im;
        acc_t                   term, qsrc;
        logic [OW-1:0]          q_re, q_im;
        acc_t                   bank_l [MAXBEATS];

        cvmac_lane #(.DW(DW), .FB(FB), .TW(TW)) u_lane (
            .op   (op_q),
            .a_re (in_a[l*EW +: DW]),
            .a_im (in_a[l*EW + DW +: DW]),
            .b_re (in_b[l*EW +: DW]),
            .b_im (in_b[l*EW + DW +: DW]),
            .k_re (kcur[DW-1:0]),
            .k_im (kcur[EW-1:DW]),
            .t_re (t_re),
            .t_im (t_im)
        );

        assign term.re = ACCW'(t_re);
        assign term.im = ACCW'(t_im);

        // first row overwrites, later rows accumulate
        always_ff @(posedge clk) begin
            if (take && red_q) begin
                if (row_cnt == '0)
                    bank_l[col_cnt[BIW-1:0]] <= term;
                else begin
                    bank_l[col_cnt[BIW-1:0]].re <= bank_l[col_cnt[BIW-1:0]].re + term.re;
                    bank_l[col_cnt[BIW-1:0]].im <= bank_l[col_cnt[BIW-1:0]].im + term.im;
                end
            end
        end

        assign qsrc = (st == ST_DRAIN) ? bank_l[col_cnt[BIW-1:0]] : term;

        cvmac_quant #(.IW(ACCW), .FB(FB), .OW(OW)) u_qre (
            .x (qsrc.re), .rnd (rnd_q), .sat (sat_q), .y (q_re)
        );
        cvmac_quant #(.IW(ACCW), .FB(FB), .OW(OW)) u_qim (
            .x (qsrc.im), .rnd (rnd_q), .sat (sat_q), .y (q_im)
        );

        assign qbeat[l*OEW +: OEW] = {q_im, q_re};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= ST_IDLE;
            op_q    <= OP_SCALE;
            red_q   <= 1'b0;
            rnd_q   <= 1'b0;
            sat_q   <= 1'b0;
            dir_q   <= 1'b0;
            kimm_q  <= '0;
            krow_q  <= '0;
            rows_q  <= '0;
            beats_q <= '0;
            row_cnt <= '0;
            col_cnt <= '0;
            ov      <= 1'b0;
            od      <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (ov && out_ready)
                ov <= 1'b0;
            unique case (st)
                ST_IDLE: begin
                    if (cmd_start) begin
                        op_q    <= vop_e'(cmd_op);
                        red_q   <= cmd_reduce;
                        rnd_q   <= cmd_round;
                        sat_q   <= cmd_sat;
                        dir_q   <= cmd_alpha_direct;
                        kimm_q  <= cmd_alpha;
                        rows_q  <= cmd_rows;
                        beats_q <= cmd_beats;
                        row_cnt <= '0;
                        col_cnt <= '0;
                        st      <= ST_RUN;
                    end
                end
                ST_RUN: begin
                    if (take) begin
                        if (!dir_q && in_first)
                            krow_q <= in_alpha;
                        if (!red_q) begin
                            ov <= 1'b1;
                            od <= qbeat;
                        end
                        if (last_col) begin
                            col_cnt <= '0;
                            if (last_row) begin
                                row_cnt <= '0;
                                st      <= red_q ? ST_DRAIN : ST_FLUSH;
                            end else begin
                                row_cnt <= row_cnt + RCW'(1);
                            end
                        end else begin
                            col_cnt <= col_cnt + BCW'(1);
                        end
                    end
                end
                ST_DRAIN: begin
                    if (out_free) begin
                        ov <= 1'b1;
                        od <= qbeat;
                        if (last_col) begin
                            col_cnt <= '0;
                            st      <= ST_FLUSH;
                        end else begin
                            col_cnt <= col_cnt + BCW'(1);
                        end
                    end
                end
                ST_FLUSH: begin
                    if (ov && out_ready) begin
                        done_q <= 1'b1;
                        st     <= ST_IDLE;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign out_valid = ov;
    assign out_data  = od;
    assign done      = done_q;
endmodule

// File: rtl/cvmac_chk.sv
module cvmac_chk #(
    parameter int ODW = 32
) (
    input logic           clk,
    input logic           rst,
    input logic           in_valid,
    input logic           in_ready,
    input logic           out_valid,
    input logic           out_ready,
    input logic [ODW-1:0] out_data,
    input logic           done,
    input logic           red_q,
    input logic           st_idle
);
    a_r10_out_hold: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    a_r10_in_stall: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready && !red_q) |-> !in_ready);

    a_r11_done_after_accept: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(out_valid && out_ready));

    a_r11_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r12_idle_no_ready: assert property (@(posedge clk) disable iff (rst)
        st_idle |-> !in_ready);

    a_r6_out_from_input: assert property (@(posedge clk) disable iff (rst)
        ($rose(out_valid) && !red_q) |-> $past(in_valid && in_ready));
endmodule

bind cvmac_core cvmac_chk #(.ODW(LANES * 2 * OW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .done      (done),
    .red_q     (red_q),
    .st_idle   (st == cvmac_pkg::ST_IDLE)
);

// File: tb/sim_cvmac_core.sv
module sim_cvmac_core;
    localparam int LANES = 2;

    logic        clk = 1'b0;
    logic        rst;
    logic        cmd_start, cmd_reduce, cmd_round, cmd_sat, cmd_alpha_direct;
    logic [1:0]  cmd_op;
    logic [15:0] cmd_alpha;
    logic [6:0]  cmd_rows;
    logic [3:0]  cmd_beats;
    logic        in_valid, in_ready, in_first;
    logic [31:0] in_a, in_b;
    logic [15:0] in_alpha;
    logic        out_valid, out_ready, done;
    logic [31:0] out_data;

    always #4 clk = ~clk;

    cvmac_core u0 (
        .clk(clk), .rst(rst), .cmd_start(cmd_start), .cmd_op(cmd_op),
        .cmd_reduce(cmd_reduce), .cmd_round(cmd_round), .cmd_sat(cmd_sat),
        .cmd_alpha_direct(cmd_alpha_direct), .cmd_alpha(cmd_alpha),
        .cmd_rows(cmd_rows), .cmd_beats(cmd_beats), .in_valid(in_valid),
        .in_ready(in_ready), .in_first(in_first), .in_a(in_a), .in_b(in_b),
        .in_alpha(in_alpha), .out_valid(out_valid), .out_ready(out_ready),
        .out_data(out_data), .done(done)
    );

    int checks = 0;
    int bad = 0;
    int unsigned seed = 32'h1234_5678;
    int total_cyc = 0;

    int ar [16][16], ai [16][16], br [16][16], bi [16][16];
    int kr [16], ki [16];
    logic [31:0] expq [$];

    function automatic int nxt();
        seed = seed * 32'd1103515245 + 32'd12345;
        return int'(seed >> 16);
    endfunction

    function automatic int pick(input int big);
        if (big != 0) return 100 + (nxt() % 28);
        return (nxt() % 121) - 60;
    endfunction

    function automatic longint fdiv16(input longint v);
        if (v >= 0) return v / 16;
        return -((-v + 15) / 16);
    endfunction

    function automatic logic [7:0] quant(input longint v, input int rnd, input int sat);
        longint f;
        f = fdiv16(v + (rnd != 0 ? 8 : 0));
        if (sat != 0) begin
            if (f > 127) f = 127;
            if (f < -128) f = -128;
        end
        return 8'(f);
    endfunction

    function automatic longint term(input int op, input int im, input int dir,
                                    input int kre, input int kim, input int i, input int c);
        int xr, xi;
        xr = (dir != 0) ? kre : kr[i];
        xi = (dir != 0) ? kim : ki[i];
        case (op)
            0: return (im != 0) ? longint'(xr*ai[i][c] + xi*ar[i][c])
                                : longint'(xr*ar[i][c] - xi*ai[i][c]);
            1: return (im != 0) ? longint'(ai[i][c]*br[i][c] - ar[i][c]*bi[i][c])
                                : longint'(ar[i][c]*br[i][c] + ai[i][c]*bi[i][c]);
            2: return (im != 0) ? longint'((ai[i][c] + bi[i][c]) * 16)
                                : longint'((ar[i][c] + br[i][c]) * 16);
            default: return 0;
        endcase
    endfunction

    task automatic fail(input string tag, input string what, input longint act, input longint exp);
        bad++;
        $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    endtask

    task automatic run_cmd(input string tag, input int op, input int red, input int rnd,
                           input int sat, input int dir, input int kre, input int kim,
                           input int rows, input int beats, input int big, input int bp);
        int nin, ip, cyc;
        bit finished, expect_done, hold_pend;
        logic [31:0] held, got, want;
        for (int i = 0; i < rows; i++) begin
            kr[i] = (nxt() % 61) - 30;
            ki[i] = (nxt() % 61) - 30;
            for (int c = 0; c < beats * LANES; c++) begin
                ar[i][c] = pick(big); ai[i][c] = pick(big);
                br[i][c] = pick(big); bi[i][c] = pick(big);
            end
        end
        // reference results
        if (red == 0) begin
            for (int i = 0; i < rows; i++)
                for (int b = 0; b < beats; b++) begin
                    logic [31:0] w;
                    for (int l = 0; l < LANES; l++) begin
                        w[l*16 +: 8]     = quant(term(op, 0, dir, kre, kim, i, b*LANES+l), rnd, sat);
                        w[l*16 + 8 +: 8] = quant(term(op, 1, dir, kre, kim, i, b*LANES+l), rnd, sat);
                    end
                    expq.push_back(w);
                end
        end else begin
            for (int b = 0; b < beats; b++) begin
                logic [31:0] w;
                for (int l = 0; l < LANES; l++) begin
                    longint sr, si;
                    sr = 0; si = 0;
                    for (int i = 0; i < rows; i++) begin
                        sr += term(op, 0, dir, kre, kim, i, b*LANES+l);
                        si += term(op, 1, dir, kre, kim, i, b*LANES+l);
                    end
                    w[l*16 +: 8]     = quant(sr, rnd, sat);
                    w[l*16 + 8 +: 8] = quant(si, rnd, sat);
                end
                expq.push_back(w);
            end
        end
        // command
        @(negedge clk);
        cmd_op = 2'(op); cmd_reduce = 1'(red); cmd_round = 1'(rnd); cmd_sat = 1'(sat);
        cmd_alpha_direct = 1'(dir); cmd_alpha = {8'(kim), 8'(kre)};
        cmd_rows = 7'(rows); cmd_beats = 4'(beats); cmd_start = 1'b1;
        @(negedge clk);
        cmd_start = 1'b0;
        nin = rows * beats; ip = 0; cyc = 0;
        finished = 0; expect_done = 0; hold_pend = 0; held = '0;
        while (!finished) begin
            in_valid = (ip < nin) && (bp == 0 || (nxt() % 4) != 0);
            if (ip < nin) begin
                int i, b;
                i = ip / beats; b = ip % beats;
                in_first = (b == 0);
                for (int l = 0; l < LANES; l++) begin
                    in_a[l*16 +: 16] = {8'(ai[i][b*LANES+l]), 8'(ar[i][b*LANES+l])};
                    in_b[l*16 +: 16] = {8'(bi[i][b*LANES+l]), 8'(br[i][b*LANES+l])};
                end
                // per-row scale shown only on the first beat; noise elsewhere
                in_alpha = (b == 0) ? {8'(ki[i]), 8'(kr[i])} : 16'(nxt());
            end
            out_ready = (bp == 0) || ((nxt() % 3) != 0);
            #3;
            if (expect_done) begin
                checks++;
                if (done !== 1'b1) fail("R11", "done after last accept", longint'(done), 1);
                finished = 1;
            end else if (done !== 1'b0) begin
                checks++;
                fail("R11", "early done", longint'(done), 0);
            end
            if (hold_pend) begin
                checks++;
                if (out_valid !== 1'b1 || out_data !== held)
                    fail("R10", "held output", longint'(out_data), longint'(held));
            end
            hold_pend = out_valid && !out_ready;
            held = out_data;
            if (out_valid && !out_ready && red == 0) begin
                checks++;
                if (in_ready !== 1'b0) fail("R10", "in_ready under stall", longint'(in_ready), 0);
            end
            if (in_valid && in_ready) ip++;
            if (out_valid && out_ready && !finished) begin
                checks++;
                got = out_data;
                if (expq.size() == 0) begin
                    fail(tag, "unexpected beat", longint'(got), 0);
                end else begin
                    want = expq.pop_front();
                    if (got !== want) fail(tag, "beat data", longint'(got), longint'(want));
                    if (expq.size() == 0) expect_done = 1;
                end
            end
            @(negedge clk);
            cyc++; total_cyc++;
            if (cyc > 20000) begin
                bad++; checks++;
                $display("FAIL %s watchdog actual=%0d expected=%0d", tag, cyc, 0);
                finished = 1;
            end
        end
        in_valid = 1'b0;
        expq.delete();
    endtask

    initial begin
        rst = 1'b1; cmd_start = 0; cmd_op = 0; cmd_reduce = 0; cmd_round = 0; cmd_sat = 0;
        cmd_alpha_direct = 0; cmd_alpha = 0; cmd_rows = 0; cmd_beats = 0;
        in_valid = 0; in_first = 0; in_a = 0; in_b = 0; in_alpha = 0; out_ready = 0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk); #3;
        checks += 3;
        if (out_valid !== 1'b0) fail("R12", "out_valid after reset", longint'(out_valid), 0);
        if (done !== 1'b0) fail("R12", "done after reset", longint'(done), 0);
        if (in_ready !== 1'b0) fail("R12", "in_ready when idle", longint'(in_ready), 0);

        run_cmd("R1/R5/R6", 0, 0, 0, 0, 1, 20, -8, 3, 2, 0, 0);
        run_cmd("R2/R7", 0, 1, 0, 0, 0, 0, 0, 4, 8, 0, 1);
        run_cmd("R3/R8/R10", 1, 0, 1, 0, 1, 0, 0, 5, 3, 0, 1);
        run_cmd("R9 sat", 1, 1, 0, 1, 1, 0, 0, 3, 4, 1, 0);
        run_cmd("R9 wrap", 0, 0, 0, 0, 1, 112, 0, 2, 2, 1, 0);
        run_cmd("R4 add", 2, 0, 1, 1, 1, 0, 0, 4, 2, 1, 1);
        run_cmd("R4 zero", 3, 0, 0, 0, 1, 5, 5, 2, 1, 0, 0);
        run_cmd("R7 single", 2, 1, 0, 0, 1, 0, 0, 1, 1, 0, 0);
        run_cmd("R7/R8 restart", 1, 1, 1, 0, 1, 0, 0, 6, 8, 0, 1);
        run_cmd("R2/R6", 0, 0, 1, 1, 0, 0, 0, 3, 4, 0, 1);

        @(negedge clk); #3;
        checks++;
        if (in_ready !== 1'b0) fail("R12", "in_ready idle at end", longint'(in_ready), 0);
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    initial begin
        #(8 * 150000);
        bad++;
        $display("FAIL global watchdog actual=%0d expected=%0d", total_cyc, 0);
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end
endmodule